// File: doc/BRIEF.md
# Data Access Translation and Fault Check

This block turns one data access request into either a physical address or exactly one fault. It sits between a load/store unit and a translation cache. The cache lookup is done elsewhere and arrives as inputs: a hit flag, a physical page number, per-mode read and write enable masks, and two trap-on-access bits. The block works out which privilege mode governs the access. It checks alignment, checks that the virtual address is canonical, and recognises the kernel-only direct-mapped window. It then picks the miss type, checks permission against the mode, catches physical addresses beyond the implemented range, and handles the uncached region.

Checks are evaluated in a fixed priority within one cycle, and the outcome is registered. A response therefore appears one clock after the request. It carries a fault code, a status vector whose bits describe the fault, a physical address, an address-valid qualifier and an uncached marker.

Top module: `dtc_xlate_check`

## Requirements
- R1: Sizes are coded as `req_size` 0..3 for 1, 2, 4 and 8 bytes. If any virtual address bit below the size in bytes is set, the fault code is 1 (alignment). The status then holds only bit 0 (store), which equals `req_write`. This check outranks every other check, including physical mode.
- R2: The mode used for permission checks depends on `req_pal`. When it is high, the mode is `alt_mode` if `req_alt` is set and mode 0 (kernel) otherwise. When `req_pal` is low, the mode is `cur_mode`.
- R3: A request with `req_phys` set skips all translation checks, and its virtual address becomes the physical address. Only R9 and R10 still apply.
- R4: A translated request is non-canonical when bits 63:42 of its virtual address are not all equal. Such a request gets fault code 2 (page fault) with status bits 5 (bad address) and 1 (access violation) set, plus bit 0 on stores.
- R5: When VA[47:41] is 0x7E the access is a direct-mapped window access and the translation cache inputs are ignored. If `cur_mode` is not 0, the fault code is 3 (access violation) with status bit 1 set, plus bit 0 on stores. Otherwise the PA is VA[43:0] with bits 43:40 forced to ones when VA bit 40 is set, and cleared to zero when it is not.
- R6: A cache miss gives fault code 5 when `req_pte` is set and code 4 otherwise. The status has bit 4 (miss) set, plus bit 0 on stores.
- R7: On a hit the PA is `tlb_ppn` shifted left by 13 with VA[12:0] added. Permission is bit [mode] of `tlb_we` for stores and of `tlb_re` for loads.
- R8: If the permission bit is clear, a store gets code 2 with status bits 1 and 0, and a load gets code 3 with status bit 1. Bit 3 is added when `tlb_fonw` is set on a store, and bit 2 when `tlb_fonr` is set on a load. If permission holds but the relevant trap bit is set, the fault code is 2 with only bit 3 and bit 0 for a store, or only bit 2 for a load.
- R9: A resulting PA with any bit at position 44 or above set gets fault code 6 (machine check) with an all-zero status.
- R10: If PA bit 43 is set and PA[43:20] are all ones, the fault code is 7 (unimplemented region) with an all-zero status. If bit 43 is set otherwise, `rsp_uncached` is raised and PA bits 42:35 are cleared.
- R11: `rsp_valid` follows `req_valid` one cycle later. A request reports exactly one fault code, following the order R1, R4, R5, R6, R8, R9, R10. Code 0 means no fault, and `rsp_pa_valid` is high only for a valid response with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | Store when high, load when low |
| req_phys | input | 1 | Physical-mode request |
| req_alt | input | 1 | Use alternate mode while privileged code runs |
| req_pte | input | 1 | Access is a page-table-entry fetch |
| req_pal | input | 1 | Request issued from privileged firmware code |
| cur_mode | input | 2 | Current privilege mode, 0 is kernel |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | Translation cache hit |
| tlb_ppn | input | 32 | Physical page number of the hit entry |
| tlb_re | input | 4 | Read enable, one bit per mode |
| tlb_we | input | 4 | Write enable, one bit per mode |
| tlb_fonr | input | 1 | Trap on read |
| tlb_fonw | input | 1 | Trap on write |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 3 | Fault code, 0 for none |
| rsp_status | output | 6 | Fault status bits |
| rsp_pa | output | 44 | Physical address |
| rsp_pa_valid | output | 1 | Address usable, no fault |
| rsp_uncached | output | 1 | Access targets the uncached region |

## Verification
The bench sweeps every combination of mode source, alternate mode, direction, enable mask and trap bit on the hit path. A design that used the current mode during privileged firmware, or tested the wrong enable mask, would fault on legal accesses or let illegal ones through. Alignment is swept over all sizes and low address bits together with physical mode, so a design that checked physical mode first would miss alignment faults. The direct-mapped window is exercised in user modes while privileged code runs, and with and without bit 40. Its targets include the uncached region and the unimplemented region, which show up wrong extension of bits 43:40 or clearing of the wrong bit range. Physical pass-through is also checked above 44 bits, and a hit with a large page number is checked for the machine-check case.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  localparam int ADDR_W     = 64;
  localparam int PA_IMPL    = 44;
  localparam int PG_SHIFT   = 13;
  localparam int VA_IMPL    = 43;
  localparam int WIN_HI     = 47;
  localparam int WIN_LO     = 41;
  localparam logic [WIN_HI-WIN_LO:0] WIN_TAG = 7'h7E;
  localparam int WIN_EXT    = 40;
  localparam int UNC_BIT    = 43;
  localparam int UNC_CLR_HI = 42;
  localparam int UNC_CLR_LO = 35;
  localparam int REG_LO     = 20;

  localparam int ST_WR   = 0;
  localparam int ST_ACV  = 1;
  localparam int ST_FONR = 2;
  localparam int ST_FONW = 3;
  localparam int ST_MISS = 4;
  localparam int ST_BAD  = 5;
  localparam int ST_W    = 6;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ALIGN    = 3'd1,
    FLT_PAGE     = 3'd2,
    FLT_ACV      = 3'd3,
    FLT_MISS     = 3'd4,
    FLT_PTE_MISS = 3'd5,
    FLT_MCHK     = 3'd6,
    FLT_UNIMP    = 3'd7
  } fault_e;

  function automatic logic misaligned(input logic [ADDR_W-1:0] va, input logic [1:0] sz);
    logic [ADDR_W-1:0] low_mask;
    low_mask = (ADDR_W'(1) << sz) - ADDR_W'(1);
    return |(va & low_mask);
  endfunction

  function automatic logic canonical(input logic [ADDR_W-1:0] va);
    return (va[ADDR_W-1:VA_IMPL-1] == '0) || (&va[ADDR_W-1:VA_IMPL-1]);
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] va);
    return va[WIN_HI:WIN_LO] == WIN_TAG;
  endfunction

  function automatic logic [ADDR_W-1:0] window_pa(input logic [ADDR_W-1:0] va);
    logic [ADDR_W-1:0] p;
    p = '0;
    p[WIN_EXT-1:0] = va[WIN_EXT-1:0];
    if (va[WIN_EXT]) p[PA_IMPL-1:WIN_EXT] = '1;
    return p;
  endfunction

  function automatic logic [ADDR_W-1:0] page_pa(input logic [ADDR_W-1:0] ppn_ext,
                                                input logic [ADDR_W-1:0] va);
    return (ppn_ext << PG_SHIFT) | (va & ((ADDR_W'(1) << PG_SHIFT) - ADDR_W'(1)));
  endfunction

  function automatic logic reg_space(input logic [ADDR_W-1:0] pa);
    return &pa[PA_IMPL-1:REG_LO];
  endfunction

  function automatic logic [ADDR_W-1:0] uncache_pa(input logic [ADDR_W-1:0] pa);
    logic [ADDR_W-1:0] p;
    p = pa;
    p[UNC_CLR_HI:UNC_CLR_LO] = '0;
    return p;
  endfunction

endpackage

// File: rtl/dtc_mode_sel.sv
module dtc_mode_sel #(
  parameter int MODE_W = 2
) (
  input  logic              pal,
  input  logic              alt_req,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  output logic [MODE_W-1:0] eff_mode
);
  always_comb begin
    if (pal) eff_mode = alt_req ? alt_mode : '0;
    else     eff_mode = cur_mode;
  end
endmodule

// File: rtl/dtc_addr_map.sv
module dtc_addr_map
  import dtc_pkg::*;
#(
  parameter int PPN_W = 32
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [PPN_W-1:0]  ppn,
  output logic              noncanon,
  output logic              window,
  output logic [ADDR_W-1:0] pa_window,
  output logic [ADDR_W-1:0] pa_page
);
  localparam int PAD_W = ADDR_W - PPN_W;

  always_comb begin
    noncanon  = !canonical(va);
    window    = in_window(va);
    pa_window = window_pa(va);
    pa_page   = page_pa({{PAD_W{1'b0}}, ppn}, va);
  end
endmodule

// File: rtl/dtc_perm.sv
module dtc_perm
  import dtc_pkg::*;
#(
  parameter int MODE_W = 2,
  localparam int NMODE = 1 << MODE_W
) (
  input  logic              write,
  input  logic [MODE_W-1:0] mode,
  input  logic [NMODE-1:0]  re_mask,
  input  logic [NMODE-1:0]  we_mask,
  input  logic              fonr,
  input  logic              fonw,
  output logic [2:0]        code,
  output logic [ST_W-1:0]   status
);
  logic allowed;
  logic trap;

  always_comb begin
    allowed = write ? we_mask[mode] : re_mask[mode];
    trap    = write ? fonw : fonr;
    code    = FLT_NONE;
    status  = '0;
    if (!allowed) begin
      code            = write ? FLT_PAGE : FLT_ACV;
      status[ST_ACV]  = 1'b1;
      status[ST_WR]   = write;
      status[ST_FONW] = write & fonw;
      status[ST_FONR] = !write & fonr;
    end else if (trap) begin
      code            = FLT_PAGE;
      status[ST_WR]   = write;
      status[ST_FONW] = write;
      status[ST_FONR] = !write;
    end
  end
endmodule

// File: rtl/dtc_xlate_check.sv
module dtc_xlate_check
  import dtc_pkg::*;
#(
  parameter int MODE_W = 2,
  parameter int PPN_W  = 32,
  parameter int PA_W   = PA_IMPL,
  localparam int NMODE = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_phys,
  input  logic              req_alt,
  input  logic              req_pte,
  input  logic              req_pal,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [NMODE-1:0]  tlb_re,
  input  logic [NMODE-1:0]  tlb_we,
  input  logic              tlb_fonr,
  input  logic              tlb_fonw,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [ST_W-1:0]   rsp_status,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_pa_valid,
  output logic              rsp_uncached
);
  logic [MODE_W-1:0] eff_mode;
  logic              am_noncanon, am_window;
  logic [ADDR_W-1:0] pa_window, pa_page;
  logic [2:0]        perm_code;
  logic [ST_W-1:0]   perm_status;

  // named events for the checker
  logic ev_misalign, ev_noncanon, ev_win_user, ev_tlb_miss;

  logic [2:0]        nx_fault;
  logic [ST_W-1:0]   nx_status;
  logic [ADDR_W-1:0] nx_pa;
  logic              nx_unc;

  dtc_mode_sel #(.MODE_W(MODE_W)) u_mode (
    .pal(req_pal), .alt_req(req_alt), .cur_mode(cur_mode),
    .alt_mode(alt_mode), .eff_mode(eff_mode)
  );

  dtc_addr_map #(.PPN_W(PPN_W)) u_map (
    .va(req_va), .ppn(tlb_ppn), .noncanon(am_noncanon), .window(am_window),
    .pa_window(pa_window), .pa_page(pa_page)
  );

  dtc_perm #(.MODE_W(MODE_W)) u_perm (
    .write(req_write), .mode(eff_mode), .re_mask(tlb_re), .we_mask(tlb_we),
    .fonr(tlb_fonr), .fonw(tlb_fonw), .code(perm_code), .status(perm_status)
  );

  always_comb begin
    nx_fault    = FLT_NONE;
    nx_status   = '0;
    nx_pa       = req_va;
    nx_unc      = 1'b0;
    ev_misalign = misaligned(req_va, req_size);
    ev_noncanon = 1'b0;
    ev_win_user = 1'b0;
    ev_tlb_miss = 1'b0;
    if (ev_misalign) begin
      nx_fault         = FLT_ALIGN;
      nx_status[ST_WR] = req_write;
    end else begin
      if (!req_phys) begin
        if (am_noncanon) begin
          ev_noncanon       = 1'b1;
          nx_fault          = FLT_PAGE;
          nx_status[ST_BAD] = 1'b1;
          nx_status[ST_ACV] = 1'b1;
          nx_status[ST_WR]  = req_write;
        end else if (am_window) begin
          if (cur_mode != '0) begin
            ev_win_user       = 1'b1;
            nx_fault          = FLT_ACV;
            nx_status[ST_ACV] = 1'b1;
            nx_status[ST_WR]  = req_write;
          end else begin
            nx_pa = pa_window;
          end
        end else if (!tlb_hit) begin
          ev_tlb_miss        = 1'b1;
          nx_fault           = req_pte ? FLT_PTE_MISS : FLT_MISS;
          nx_status[ST_MISS] = 1'b1;
          nx_status[ST_WR]   = req_write;
        end else begin
          nx_pa     = pa_page;
          nx_fault  = perm_code;
          nx_status = perm_status;
        end
      end
      if (nx_fault == FLT_NONE) begin
        if (|nx_pa[ADDR_W-1:PA_IMPL]) begin
          nx_fault = FLT_MCHK;
        end else if (nx_pa[UNC_BIT]) begin
          if (reg_space(nx_pa)) begin
            nx_fault = FLT_UNIMP;
          end else begin
            nx_unc = 1'b1;
            nx_pa  = uncache_pa(nx_pa);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= FLT_NONE;
      rsp_status   <= '0;
      rsp_pa       <= '0;
      rsp_pa_valid <= 1'b0;
      rsp_uncached <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_fault    <= req_valid ? nx_fault : FLT_NONE;
      rsp_status   <= req_valid ? nx_status : '0;
      rsp_pa_valid <= req_valid && (nx_fault == FLT_NONE);
      rsp_uncached <= req_valid && (nx_fault == FLT_NONE) && nx_unc;
      rsp_pa       <= (req_valid && nx_fault == FLT_NONE) ? nx_pa[PA_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/dtc_xlate_check_sva.sv
module dtc_xlate_check_sva
  import dtc_pkg::*;
#(
  parameter int PA_W = PA_IMPL
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            req_pte,
  input logic            ev_misalign,
  input logic            ev_noncanon,
  input logic            ev_win_user,
  input logic            ev_tlb_miss,
  input logic            rsp_valid,
  input logic [2:0]      rsp_fault,
  input logic [ST_W-1:0] rsp_status,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_pa_valid,
  input logic            rsp_uncached
);
  assert_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ev_misalign |=> rsp_fault == FLT_ALIGN &&
      rsp_status == {{(ST_W-1){1'b0}}, $past(req_write)});

  assert_badva_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ev_noncanon |=> rsp_fault == FLT_PAGE &&
      rsp_status[ST_BAD] && rsp_status[ST_ACV]);

  assert_window_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ev_win_user |=> rsp_fault == FLT_ACV && rsp_status[ST_ACV]);

  assert_miss_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ev_tlb_miss |=> rsp_status[ST_MISS] &&
      rsp_fault == ($past(req_pte) ? FLT_PTE_MISS : FLT_MISS));

  assert_quiet_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault == FLT_MCHK || rsp_fault == FLT_UNIMP) |-> rsp_status == '0);

  assert_uncached_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncached |-> rsp_pa_valid && rsp_pa[UNC_BIT] && rsp_pa[UNC_CLR_HI:UNC_CLR_LO] == '0);

  assert_resp_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_resp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_pa_valid);

  assert_pa_qual_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pa_valid |-> rsp_valid && rsp_fault == FLT_NONE);
endmodule

bind dtc_xlate_check dtc_xlate_check_sva #(.PA_W(PA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_pte(req_pte), .ev_misalign(ev_misalign), .ev_noncanon(ev_noncanon),
  .ev_win_user(ev_win_user), .ev_tlb_miss(ev_tlb_miss), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_status(rsp_status), .rsp_pa(rsp_pa),
  .rsp_pa_valid(rsp_pa_valid), .rsp_uncached(rsp_uncached)
);

// File: tb/dtc_xlate_check_tb.sv
module dtc_xlate_check_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [63:0] t_va = '0;
  logic [1:0]  t_size = '0;
  logic        t_write = 1'b0, t_phys = 1'b0, t_alt = 1'b0, t_pte = 1'b0, t_pal = 1'b0;
  logic [1:0]  t_cm = '0, t_am = '0;
  logic        t_hit = 1'b0;
  logic [31:0] t_ppn = '0;
  logic [3:0]  t_re = '0, t_we = '0;
  logic        t_fonr = 1'b0, t_fonw = 1'b0;

  logic        rsp_valid, rsp_pa_valid, rsp_uncached;
  logic [2:0]  rsp_fault;
  logic [5:0]  rsp_status;
  logic [43:0] rsp_pa;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [5:0] B_WR = 6'd1, B_ACV = 6'd2, B_FONR = 6'd4,
                         B_FONW = 6'd8, B_MISS = 6'd16, B_BAD = 6'd32;

  dtc_xlate_check dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(t_va),
    .req_size(t_size), .req_write(t_write), .req_phys(t_phys), .req_alt(t_alt),
    .req_pte(t_pte), .req_pal(t_pal), .cur_mode(t_cm), .alt_mode(t_am),
    .tlb_hit(t_hit), .tlb_ppn(t_ppn), .tlb_re(t_re), .tlb_we(t_we),
    .tlb_fonr(t_fonr), .tlb_fonw(t_fonw), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_status(rsp_status), .rsp_pa(rsp_pa),
    .rsp_pa_valid(rsp_pa_valid), .rsp_uncached(rsp_uncached)
  );

  function automatic void model(output logic [2:0] ef, output logic [5:0] es,
                                output logic [63:0] ep, output logic eu);
    logic [63:0] a;
    logic [63:0] nbytes;
    logic [1:0]  m;
    logic        ok, trap;
    logic [5:0]  wr;
    ef = 3'd0; es = '0; ep = '0; eu = 1'b0;
    wr = t_write ? B_WR : 6'd0;
    nbytes = 64'd1 << t_size;
    if ((t_va % nbytes) != 0) begin ef = 3'd1; es = wr; return; end
    m = t_pal ? (t_alt ? t_am : 2'd0) : t_cm;
    if (t_phys) begin
      a = t_va;
    end else begin
      if ((($signed(t_va) <<< 21) >>> 21) != $signed(t_va)) begin
        ef = 3'd2; es = B_BAD | B_ACV | wr; return;
      end
      if (t_va[47:41] == 7'b1111110) begin
        if (t_cm != 2'd0) begin ef = 3'd3; es = B_ACV | wr; return; end
        a = t_va & ((64'd1 << 40) - 64'd1);
        if (t_va[40]) a = a + (64'd15 << 40);
      end else begin
        if (!t_hit) begin ef = t_pte ? 3'd5 : 3'd4; es = B_MISS | wr; return; end
        a = 64'(t_ppn) * 64'd8192 + (t_va % 64'd8192);
        ok   = t_write ? t_we[m] : t_re[m];
        trap = t_write ? t_fonw : t_fonr;
        if (!ok) begin
          ef = t_write ? 3'd2 : 3'd3;
          es = B_ACV | wr | (trap ? (t_write ? B_FONW : B_FONR) : 6'd0);
          return;
        end
        if (trap) begin ef = 3'd2; es = t_write ? (B_FONW | B_WR) : B_FONR; return; end
      end
    end
    if (a >= (64'd1 << 44)) begin ef = 3'd6; return; end
    if (a >= (64'd1 << 43)) begin
      if (a >= 64'hFFF_FFF0_0000) begin ef = 3'd7; return; end
      eu = 1'b1;
      a = a & ~(64'hFF << 35);
    end
    ep = a;
  endfunction

  // drives at a falling edge, checks at the next falling edge (one register)
  task automatic issue(input string req);
    logic [2:0] ef; logic [5:0] es; logic [63:0] ep; logic eu;
    logic mism;
    req_valid = 1'b1;
    model(ef, es, ep, eu);
    @(negedge clk);
    total++;
    mism = (rsp_valid !== 1'b1) || (rsp_fault !== ef) || (rsp_status !== es) ||
           (rsp_pa_valid !== (ef == 3'd0)) ||
           ((ef == 3'd0) && ((rsp_pa !== ep[43:0]) || (rsp_uncached !== eu)));
    if (mism) begin
      bad++;
      $display("FAIL %s va=%h: got v=%b f=%0d st=%b pa=%h pv=%b u=%b exp f=%0d st=%b pa=%h u=%b",
               req, t_va, rsp_valid, rsp_fault, rsp_status, rsp_pa, rsp_pa_valid,
               rsp_uncached, ef, es, ep[43:0], eu);
    end
  endtask

  task automatic clear_req();
    t_size = 2'd0; t_write = 1'b0; t_phys = 1'b0; t_alt = 1'b0; t_pte = 1'b0;
    t_pal = 1'b0; t_cm = 2'd0; t_am = 2'd0; t_hit = 1'b0; t_ppn = '0;
    t_re = '0; t_we = '0; t_fonr = 1'b0; t_fonw = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R11 watchdog expired: got running, expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // reset state, R11
    total++;
    if (rsp_valid !== 1'b0 || rsp_pa_valid !== 1'b0 || rsp_uncached !== 1'b0) begin
      bad++;
      $display("FAIL R11 reset: got v=%b pv=%b u=%b expected 0 0 0",
               rsp_valid, rsp_pa_valid, rsp_uncached);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 with R3: alignment outranks physical mode
    clear_req();
    for (int sz = 0; sz < 4; sz++)
      for (int lo = 0; lo < 8; lo++)
        for (int w = 0; w < 2; w++) begin
          t_phys = 1'b1; t_size = 2'(sz); t_write = w[0];
          t_va = 64'h0000_0012_3450_0000 + 64'(lo);
          issue("R1");
        end

    // R2, R7, R8: hit path over every mode source, mask and trap bit
    clear_req();
    t_hit = 1'b1;
    for (int cm = 0; cm < 4; cm++)
      for (int pal = 0; pal < 2; pal++)
        for (int alt = 0; alt < 2; alt++)
          for (int am = 0; am < 4; am++)
            for (int w = 0; w < 2; w++)
              for (int mk = 0; mk < 16; mk++)
                for (int fo = 0; fo < 2; fo++) begin
                  t_cm = 2'(cm); t_pal = pal[0]; t_alt = alt[0]; t_am = 2'(am);
                  t_write = w[0]; t_re = 4'(mk); t_we = 4'(mk);
                  t_fonr = fo[0]; t_fonw = fo[0];
                  t_ppn = 32'h0001_2000 + 32'(mk * 7);
                  t_va = 64'h0000_0000_0567_8000 + 64'(mk * 8 + w * 4);
                  issue("R2_R7_R8");
                end

    // R8: load trap with store trap set only (and vice versa)
    t_re = 4'hF; t_we = 4'hF; t_pal = 1'b0; t_cm = 2'd3;
    t_write = 1'b0; t_fonr = 1'b0; t_fonw = 1'b1; issue("R8");
    t_write = 1'b1; t_fonr = 1'b1; t_fonw = 1'b0; issue("R8");

    // R6 miss kinds
    clear_req();
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 2; w++) begin
        t_pte = p[0]; t_write = w[0]; t_va = 64'h0000_0001_0000_2000; t_ppn = 32'hFFFF_FFFF;
        issue("R6");
      end

    // R4 non-canonical addresses, translated only
    clear_req();
    for (int w = 0; w < 2; w++) begin
      t_write = w[0]; t_hit = 1'b1; t_re = 4'hF; t_we = 4'hF;
      t_va = 64'h0000_0400_0000_0000; issue("R4");
      t_va = 64'h8000_0000_0000_0000; issue("R4");
      t_va = 64'hFFFF_F800_0000_1000; issue("R4");
    end

    // R5 window, current mode decides; bit 40 extension, R10 regions
    clear_req();
    for (int cm = 0; cm < 4; cm++)
      for (int pal = 0; pal < 2; pal++)
        for (int w = 0; w < 2; w++)
          for (int k = 0; k < 4; k++) begin
            t_cm = 2'(cm); t_pal = pal[0]; t_alt = 1'b0; t_write = w[0];
            t_hit = k[0]; t_re = 4'h0; t_we = 4'h0;
            case (k)
              0: t_va = 64'hFFFF_FC01_2345_6780;
              1: t_va = 64'hFFFF_FD00_0000_1000;
              2: t_va = 64'hFFFF_FDFF_FFF0_0000;
              default: t_va = 64'hFFFF_FCAB_CDEF_0008;
            endcase
            issue("R5");
          end

    // R3 and R9, R10 in physical mode
    clear_req();
    t_phys = 1'b1;
    t_va = 64'h0000_0012_3456_7890; issue("R3");
    t_va = 64'h0000_1000_0000_0000; issue("R9");
    t_va = 64'h8000_0000_0000_0000; issue("R9");
    t_va = 64'h0000_0800_1234_5678; issue("R10");
    t_va = 64'h0000_0FFF_FFF0_0010; issue("R10");
    t_va = 64'h0000_0FFF_FFEF_FFF8; issue("R10");

    // R9 through a hit with a large page number
    clear_req();
    t_hit = 1'b1; t_re = 4'hF; t_va = 64'h0000_0000_0000_0040;
    t_ppn = 32'h8000_0001; issue("R9");
    t_ppn = 32'h7FFF_FFFF; issue("R10");

    // R11 idle cycle gives no response
    req_valid = 1'b0;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_pa_valid !== 1'b0) begin
      bad++;
      $display("FAIL R11 idle: got v=%b pv=%b expected 0 0", rsp_valid, rsp_pa_valid);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule